// File: doc/BRIEF.md
# Flash Erase Status Poller

This block forms the byte that a host sees when it reads a parallel NOR flash while the internal program/erase controller is busy. Each bus read reports the current operation state in a status byte. The byte carries a data-polling bit, a free-running toggle bit, an error flag, an erase-timer flag, and a second toggle bit that responds only to reads that fall inside particular blocks. When no operation is active, the block passes array data through unchanged. It does the same for reads from blocks that are not being erased while an erase is suspended.

The host starts a read by raising `rd_strobe`. The block counts only that rising edge, so holding the strobe high does not count as further reads. The address decoder supplies the block index of the read. The command logic supplies the operation state, a pulse that marks the start of each new operation, a mask of the blocks selected for erase, and a mask of the blocks that failed to erase. Because the second toggle bit depends on the address, a host can walk the address space and find which blocks are still being erased or which ones failed.

Top module: `flash_status_poll`

## Requirements
- R1: With `op_state` = 0 (read mode), `dout` equals `array_data`, and reads leave both toggle bits unchanged.
- R2: Bit 6 flips on each read start while `op_state` is 1 (program), 2 (program error), 3 (chip erase), 4 (block erase, timer open), 5 (block erase running) or 7 (erase error), whatever the block. In states 0 and 6 (erase suspend) it holds its value.
- R3: Bit 2 flips on a read start in states 3, 4, 5 and 6 only when `erase_sel` has a 1 at the read's block. In state 7 it flips only when `erase_fail` has a 1 there. In every other case it holds its value.
- R4: A block index of `NUM_BLOCKS` or above counts as neither selected nor failed. Protected blocks are handled by keeping them out of both masks.
- R5: In state 6, a read from a block not selected for erase returns `array_data`. A read from a selected block returns the status byte.
- R6: Bit 3 of the status byte is 1 in states 3, 5 and 7, and 0 in all other states. In particular it is 0 in state 4, while more blocks may still be added.
- R7: Bit 5 of the status byte is 1 in states 2 and 7, and 0 in all other states.
- R8: Bit 7 of the status byte is the inverse of `prog_msb` in states 1 and 2. In the erase states 3 to 7 it is 0.
- R9: Bits 4, 1 and 0 of the status byte, and all bits above bit 7 of `dout`, are 0.
- R10: A read start is a rising edge of `rd_strobe`. Keeping the strobe high for further cycles causes no further flip.
- R11: A cycle with `op_start` high clears both toggle bits to 0, even if a read starts in the same cycle.
- R12: After reset both toggle bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | Bus read strobe; its rising edge marks one read |
| rd_block | input | BLK_W | Block index decoded from the read address |
| op_state | input | 3 | Current controller state (encoding in R1 to R8) |
| op_start | input | 1 | One-cycle pulse when a new program or erase begins |
| erase_sel | input | NUM_BLOCKS | Blocks selected for erase |
| erase_fail | input | NUM_BLOCKS | Blocks that did not erase correctly |
| prog_msb | input | 1 | Bit 7 of the data being programmed |
| array_data | input | DATA_W | Normal array read data |
| dout | output | DATA_W | Status byte or array data |

## Verification
The bench builds the block with NUM_BLOCKS = 6 and DATA_W = 16. With six blocks, the 3-bit block index has two codes, 6 and 7, that name no block, so the out-of-range handling of R4 gets exercised even when both masks are all ones. The 16-bit data path puts bits above the status byte within reach: they must read as array data in read mode and as 0 while status is shown. Random reads across all eight states check both toggle bits against a model in the bench over many read sequences, and directed cases cover a held strobe, a start pulse that meets a read, and the suspend pass-through.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        FSP_OP_IDLE       = 3'd0,
        FSP_OP_PROG       = 3'd1,
        FSP_OP_PROG_ERR   = 3'd2,
        FSP_OP_CHIP_ERASE = 3'd3,
        FSP_OP_BLK_OPEN   = 3'd4,
        FSP_OP_BLK_RUN    = 3'd5,
        FSP_OP_SUSPEND    = 3'd6,
        FSP_OP_ERASE_ERR  = 3'd7
    } fsp_op_e;

    // Layout of the status byte; positions are what the host decodes.
    typedef struct packed {
        logic       poll;     // bit 7
        logic       tgl_any;  // bit 6
        logic       fault;    // bit 5
        logic       rsvd4;    // bit 4
        logic       timer;    // bit 3
        logic       tgl_blk;  // bit 2
        logic [1:0] rsvd10;   // bits 1..0
    } fsp_status_t;

    localparam int FSP_STATUS_W = $bits(fsp_status_t);

    // Indices of the two toggle registers.
    localparam int FSP_TGL_ANY = 0;
    localparam int FSP_TGL_BLK = 1;
    localparam int FSP_TGL_N   = 2;

    function automatic logic op_is_program(fsp_op_e op);
        return (op == FSP_OP_PROG) || (op == FSP_OP_PROG_ERR);
    endfunction

    function automatic logic op_flips_any(fsp_op_e op);
        return (op != FSP_OP_IDLE) && (op != FSP_OP_SUSPEND);
    endfunction

    function automatic logic op_erasing(fsp_op_e op);
        return (op == FSP_OP_CHIP_ERASE) || (op == FSP_OP_BLK_OPEN) ||
               (op == FSP_OP_BLK_RUN)    || (op == FSP_OP_SUSPEND);
    endfunction

    function automatic logic op_timer_bit(fsp_op_e op);
        return (op == FSP_OP_CHIP_ERASE) || (op == FSP_OP_BLK_RUN) ||
               (op == FSP_OP_ERASE_ERR);
    endfunction

    function automatic logic op_fault_bit(fsp_op_e op);
        return (op == FSP_OP_PROG_ERR) || (op == FSP_OP_ERASE_ERR);
    endfunction

endpackage

// File: rtl/fsp_rd_edge.sv
module fsp_rd_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise,
    output logic prev
);
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= strobe;
    end

    assign rise = strobe & ~prev;
endmodule

// File: rtl/fsp_blk_lookup.sv
module fsp_blk_lookup #(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = 3
) (
    input  logic [BLK_W-1:0]      blk,
    input  logic [NUM_BLOCKS-1:0] sel_mask,
    input  logic [NUM_BLOCKS-1:0] fail_mask,
    output logic                  sel_hit,
    output logic                  fail_hit
);
    logic in_range;

    assign in_range = (32'(blk) < 32'(NUM_BLOCKS));

    always_comb begin
        sel_hit  = 1'b0;
        fail_hit = 1'b0;
        if (in_range) begin
            sel_hit  = sel_mask[blk];
            fail_hit = fail_mask[blk];
        end
    end
endmodule

// File: rtl/fsp_tgl_reg.sv
module fsp_tgl_reg (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= 1'b0;
        else if (adv)   q <= ~q;
    end
endmodule

// File: rtl/fsp_status_fmt.sv
module fsp_status_fmt
    import fsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fsp_op_e           op,
    input  logic              tgl_any,
    input  logic              tgl_blk,
    input  logic              sel_hit,
    input  logic              prog_msb,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dout
);
    fsp_status_t st;
    logic        show_status;

    always_comb begin
        st         = '0;
        st.poll    = op_is_program(op) ? ~prog_msb : 1'b0;
        st.tgl_any = tgl_any;
        st.fault   = op_fault_bit(op);
        st.timer   = op_timer_bit(op);
        st.tgl_blk = tgl_blk;
    end

    always_comb begin
        show_status = 1'b1;
        if (op == FSP_OP_IDLE)                    show_status = 1'b0;
        else if (op == FSP_OP_SUSPEND && !sel_hit) show_status = 1'b0;
    end

    always_comb begin
        if (show_status) begin
            dout                   = '0;
            dout[FSP_STATUS_W-1:0] = st;
        end else begin
            dout = array_data;
        end
    end
endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll
    import fsp_pkg::*;
#(
    parameter  int NUM_BLOCKS = 8,
    parameter  int DATA_W     = 8,
    localparam int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_strobe,
    input  logic [BLK_W-1:0]      rd_block,
    input  logic [2:0]            op_state,
    input  logic                  op_start,
    input  logic [NUM_BLOCKS-1:0] erase_sel,
    input  logic [NUM_BLOCKS-1:0] erase_fail,
    input  logic                  prog_msb,
    input  logic [DATA_W-1:0]     array_data,
    output logic [DATA_W-1:0]     dout
);
    fsp_op_e              op;
    logic                 rd_rise;
    logic                 rd_prev;
    logic                 sel_hit;
    logic                 fail_hit;
    logic [FSP_TGL_N-1:0] tgl_adv;
    logic [FSP_TGL_N-1:0] tgl_q;
    logic                 tgl_main;
    logic                 tgl_alt;

    assign op = fsp_op_e'(op_state);

    fsp_rd_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (rd_strobe),
        .rise   (rd_rise),
        .prev   (rd_prev)
    );

    fsp_blk_lookup #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_lookup (
        .blk       (rd_block),
        .sel_mask  (erase_sel),
        .fail_mask (erase_fail),
        .sel_hit   (sel_hit),
        .fail_hit  (fail_hit)
    );

    always_comb begin
        tgl_adv              = '0;
        tgl_adv[FSP_TGL_ANY] = rd_rise && op_flips_any(op);
        tgl_adv[FSP_TGL_BLK] = rd_rise &&
            ((op_erasing(op) && sel_hit) ||
             (op == FSP_OP_ERASE_ERR && fail_hit));
    end

    for (genvar g = 0; g < FSP_TGL_N; g++) begin : g_tgl
        fsp_tgl_reg u_tgl (
            .clk (clk),
            .rst (rst),
            .clr (op_start),
            .adv (tgl_adv[g]),
            .q   (tgl_q[g])
        );
    end

    assign tgl_main = tgl_q[FSP_TGL_ANY];
    assign tgl_alt  = tgl_q[FSP_TGL_BLK];

    fsp_status_fmt #(
        .DATA_W (DATA_W)
    ) u_fmt (
        .op         (op),
        .tgl_any    (tgl_main),
        .tgl_blk    (tgl_alt),
        .sel_hit    (sel_hit),
        .prog_msb   (prog_msb),
        .array_data (array_data),
        .dout       (dout)
    );
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker
    import fsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_strobe,
    input logic              rd_prev,
    input logic              op_start,
    input logic [2:0]        op_state,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] dout,
    input logic              tgl_main,
    input logic              tgl_alt
);
    AST_READ_MODE_DATA: assert property (@(posedge clk) disable iff (rst)
        op_state == FSP_OP_IDLE |-> dout == array_data); // R1

    AST_READ_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (op_state == FSP_OP_IDLE && !op_start) |=> ($stable(tgl_main) && $stable(tgl_alt))); // R1

    AST_SUSPEND_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_state == FSP_OP_SUSPEND && !op_start) |=> $stable(tgl_main)); // R2

    AST_TIMER_OPEN: assert property (@(posedge clk) disable iff (rst)
        op_state == FSP_OP_BLK_OPEN |-> !dout[3]); // R6

    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (op_state == FSP_OP_PROG_ERR || op_state == FSP_OP_ERASE_ERR) |-> dout[5]); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_state != FSP_OP_IDLE && op_state != FSP_OP_SUSPEND) |-> (dout[4] == 1'b0 && dout[1:0] == 2'b00)); // R9

    AST_LEVEL_NO_FLIP: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_prev && !op_start) |=> ($stable(tgl_main) && $stable(tgl_alt))); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        op_start |=> (!tgl_main && !tgl_alt)); // R11
endmodule

bind flash_status_poll fsp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_strobe  (rd_strobe),
    .rd_prev    (rd_prev),
    .op_start   (op_start),
    .op_state   (op_state),
    .array_data (array_data),
    .dout       (dout),
    .tgl_main   (tgl_main),
    .tgl_alt    (tgl_alt)
);

// File: tb/flash_status_poll_tb_top.sv
module flash_status_poll_tb_top;
    localparam int NB = 6;
    localparam int DW = 16;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_strobe = 1'b0;
    logic [BW-1:0] rd_block = '0;
    logic [2:0]    op_state = 3'd0;
    logic          op_start = 1'b0;
    logic [NB-1:0] erase_sel = '0;
    logic [NB-1:0] erase_fail = '0;
    logic          prog_msb = 1'b0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] dout;

    int  total = 0;
    int  bad = 0;
    bit  m_main = 1'b0;
    bit  m_alt = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    flash_status_poll #(.NUM_BLOCKS(NB), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_block(rd_block),
        .op_state(op_state), .op_start(op_start), .erase_sel(erase_sel),
        .erase_fail(erase_fail), .prog_msb(prog_msb),
        .array_data(array_data), .dout(dout)
    );

    function automatic bit f_main_flips(logic [2:0] op);
        return (op != 3'd0) && (op != 3'd6);
    endfunction

    function automatic bit f_in_mask(logic [NB-1:0] m, logic [BW-1:0] b);
        return (int'(b) < NB) ? m[b] : 1'b0;
    endfunction

    function automatic bit f_alt_flips(logic [2:0] op, logic [BW-1:0] b,
                                       logic [NB-1:0] s, logic [NB-1:0] f);
        if (op >= 3'd3 && op <= 3'd6) return f_in_mask(s, b);
        if (op == 3'd7) return f_in_mask(f, b);
        return 1'b0;
    endfunction

    function automatic logic [DW-1:0] f_expect(logic [2:0] op, logic [BW-1:0] b,
            logic [NB-1:0] s, logic [DW-1:0] arr, logic pm, bit tm, bit ta);
        logic [DW-1:0] e;
        if (op == 3'd0) return arr;
        if (op == 3'd6 && !f_in_mask(s, b)) return arr;
        e = '0;
        e[7] = (op == 3'd1 || op == 3'd2) ? ~pm : 1'b0;
        e[6] = tm;
        e[5] = (op == 3'd2 || op == 3'd7);
        e[3] = (op == 3'd3 || op == 3'd5 || op == 3'd7);
        e[2] = ta;
        return e;
    endfunction

    task automatic check(logic [DW-1:0] act, logic [DW-1:0] exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: dout=%h expected=%h", tag, act, exp);
        end
    endtask

    // One read: rising strobe at a negedge, checked one cycle later.
    task automatic do_read(logic [2:0] op, logic [BW-1:0] b, logic [NB-1:0] s,
                           logic [NB-1:0] f, logic [DW-1:0] arr, logic pm, string tag);
        @(negedge clk);
        op_state = op; rd_block = b; erase_sel = s; erase_fail = f;
        array_data = arr; prog_msb = pm; rd_strobe = 1'b1;
        if (f_main_flips(op)) m_main = ~m_main;
        if (f_alt_flips(op, b, s, f)) m_alt = ~m_alt;
        @(negedge clk);
        check(dout, f_expect(op, b, s, arr, pm, m_main, m_alt), tag);
        rd_strobe = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        m_main = 1'b0; m_alt = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12: toggles clear after reset; chip erase shows timer bit only.
        @(negedge clk);
        op_state = 3'd3; erase_sel = '1;
        @(negedge clk);
        check(dout, 16'h0008, "R12 reset state");

        // R2 R6: chip erase reads flip both toggles.
        do_read(3'd3, 3'd1, '1, '0, 16'hAAAA, 1'b0, "R2 R3 R6 chip erase");
        do_read(3'd3, 3'd2, '1, '0, 16'hAAAA, 1'b0, "R2 R3 chip erase second");

        // R4: out-of-range block never flips bit 2.
        do_read(3'd5, 3'd6, '1, '1, 16'h1234, 1'b0, "R4 block six");
        do_read(3'd7, 3'd7, '1, '1, 16'h1234, 1'b0, "R4 R7 block seven");

        // R6: timer bit low with the timer still open.
        do_read(3'd4, 3'd0, 6'b000001, '0, 16'h0, 1'b0, "R6 timer open");

        // R5: suspend pass-through and status for a selected block.
        do_read(3'd6, 3'd1, 6'b000001, '0, 16'hBEEF, 1'b0, "R5 suspend unselected");
        do_read(3'd6, 3'd0, 6'b000001, '0, 16'hBEEF, 1'b0, "R5 R3 suspend selected");

        // R3: erase error toggles only on failed blocks.
        do_read(3'd7, 3'd2, '1, 6'b000100, 16'h0, 1'b0, "R3 failed block");
        do_read(3'd7, 3'd3, '1, 6'b000100, 16'h0, 1'b0, "R3 good block");

        // R8: program polling bit.
        do_read(3'd1, 3'd0, '0, '0, 16'h0, 1'b0, "R8 program msb0");
        do_read(3'd2, 3'd0, '0, '0, 16'h0, 1'b1, "R8 R7 program error msb1");

        // R1: read mode passes data; toggles seen unchanged afterwards.
        do_read(3'd0, 3'd0, '1, '1, 16'hC3C3, 1'b0, "R1 read mode");
        do_read(3'd0, 3'd1, '1, '1, 16'h5A5A, 1'b0, "R1 read mode again");
        @(negedge clk);
        op_state = 3'd6; rd_block = 3'd0; erase_sel = '1;
        @(negedge clk);
        check(dout, f_expect(3'd6, 3'd0, '1, '0, 1'b0, m_main, m_alt), "R1 toggles held");

        // R10: strobe held high flips once only.
        @(negedge clk);
        op_state = 3'd5; rd_block = 3'd0; erase_sel = '1; rd_strobe = 1'b1;
        m_main = ~m_main; m_alt = ~m_alt;
        repeat (4) @(negedge clk);
        check(dout, f_expect(3'd5, 3'd0, '1, '0, 1'b0, m_main, m_alt), "R10 held strobe");
        rd_strobe = 1'b0;

        // R11: start pulse meets a read start.
        @(negedge clk);
        op_start = 1'b1; rd_strobe = 1'b1; op_state = 3'd3;
        @(negedge clk);
        op_start = 1'b0;
        m_main = 1'b0; m_alt = 1'b0;
        check(dout, 16'h0008, "R11 start wins over read");
        rd_strobe = 1'b0;

        // Random mix over all states.
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 15) == 0) pulse_start();
            do_read(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                    NB'($urandom), NB'($urandom), DW'($urandom), 1'($urandom),
                    "R2 R3 R5 R8 R9 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=50000 expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule